// File: doc/BRIEF.md
# Wide Vector Lane Shuffle Unit

A single-cycle shuffle datapath for 256-bit vectors. Each accepted request carries two 256-bit vector operands (`vec_a`, `vec_b`), a 128-bit scalar operand, a 4-bit operation code and an 8-bit immediate. The unit produces one 256-bit result, which is registered one clock edge after the request.

The unit supports these operations:
- broadcasts of a scalar element of several widths;
- insertion or extraction of one 128-bit half;
- permutes that stay inside each 128-bit lane;
- permutes that cross the lane boundary, taking per-element indices from `vec_b`;
- a selector that builds each result half from any 128-bit quarter of the two vectors, or forces that half to zero.

The unit sits beside a vector register file. Decode, memory access and arithmetic belong elsewhere.

Top module: `vshuf_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res_valid` and `res_data` become zero at that edge.
- R2: `res_valid` equals `req_valid` one cycle later. If `req_valid` is low, `res_data` keeps its previous value.
- R3: Op codes 0 to 4 broadcast the low 8, 16, 32, 64 or 128 bits of `scalar` (in that order) into every element of the result.
- R4: Op code 5 (insert) copies `vec_a` and replaces one half with `scalar`: the low half when `imm[0]`=0, the high half when `imm[0]`=1.
- R5: Op code 6 (extract) places `vec_a` bits [127:0] (`imm[0]`=0) or [255:128] (`imm[0]`=1) into `res_data[127:0]` and zeroes `res_data[255:128]`.
- R6: Op code 7 (in-lane 32-bit permute): result element i (32-bit, i=0..7) is `vec_a` element 4*(i/4) + `vec_b`[32i+1:32i]. No element moves across the 128-bit boundary.
- R7: Op code 8 (in-lane 64-bit permute): result element i (64-bit, i=0..3) is `vec_a` element 2*(i/2) + `vec_b`[64i].
- R8: Op code 9 (cross-lane 32-bit permute): result element i is `vec_a` element `vec_b`[32i+2:32i].
- R9: Op code 10 (cross-lane 64-bit permute): result element i is `vec_a` 64-bit element `vec_b`[64i+1:64i].
- R10: Op code 11 (quarter select) uses this quarter code: 0 = `vec_a` low half, 1 = `vec_a` high half, 2 = `vec_b` low half, 3 = `vec_b` high half. The low result half takes the quarter coded by `imm[1:0]` and is zero if `imm[3]`=1. The high result half takes the quarter coded by `imm[5:4]` and is zero if `imm[7]`=1. `imm[2]` and `imm[6]` have no effect.
- R11: Op codes 12 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code |
| imm | input | 8 | Immediate control byte |
| vec_a | input | 256 | First vector operand |
| vec_b | input | 256 | Second vector operand / index vector |
| scalar | input | 128 | Scalar operand for broadcast and insert |
| res_valid | output | 1 | Result valid |
| res_data | output | 256 | Registered result |

## Verification
The unit's only state is the result register and its valid flag. A fault inside the unit therefore appears at the ports on the very next cycle. It shows up as:
- a wrong element,
- data from the wrong lane,
- a half that should be zero and is not,
- a result that changes when no request is present.

The bench sweeps every quarter-select immediate and every broadcast width. It also applies many pseudo-random index vectors to each permute. It compares each result with a model computed from the requirements. Lane leakage appears as a miscompare at once.

// File: rtl/vshuf_pkg.sv
package vshuf_pkg;
    localparam int VW   = 256;
    localparam int HW   = VW / 2;
    localparam int N32  = VW / 32;
    localparam int N64  = VW / 64;
    localparam int PER_LANE32 = HW / 32;
    localparam int PER_LANE64 = HW / 64;

    typedef enum logic [3:0] {
        OP_BC8    = 4'd0,
        OP_BC16   = 4'd1,
        OP_BC32   = 4'd2,
        OP_BC64   = 4'd3,
        OP_BC128  = 4'd4,
        OP_INSERT = 4'd5,
        OP_EXTRACT= 4'd6,
        OP_PIN32  = 4'd7,
        OP_PIN64  = 4'd8,
        OP_PX32   = 4'd9,
        OP_PX64   = 4'd10,
        OP_QSEL   = 4'd11
    } vshuf_op_e;

    typedef struct packed {
        logic [HW-1:0] hi;
        logic [HW-1:0] lo;
    } vec_halves_t;

    function automatic logic [HW-1:0] pick_quarter(input vec_halves_t a,
                                                   input vec_halves_t b,
                                                   input logic [1:0] code);
        case (code)
            2'd0:    pick_quarter = a.lo;
            2'd1:    pick_quarter = a.hi;
            2'd2:    pick_quarter = b.lo;
            default: pick_quarter = b.hi;
        endcase
    endfunction
endpackage

// File: rtl/vshuf_bcast.sv
module vshuf_bcast
    import vshuf_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [HW-1:0] scalar,
    output logic [VW-1:0] bc_out
);
    always_comb begin
        case (op)
            OP_BC8:   bc_out = {(VW/8){scalar[7:0]}};
            OP_BC16:  bc_out = {(VW/16){scalar[15:0]}};
            OP_BC32:  bc_out = {(VW/32){scalar[31:0]}};
            OP_BC64:  bc_out = {(VW/64){scalar[63:0]}};
            default:  bc_out = {(VW/HW){scalar}};
        endcase
    end
endmodule

// File: rtl/vshuf_half.sv
module vshuf_half
    import vshuf_pkg::*;
(
    input  vec_halves_t   vec_a,
    input  logic [HW-1:0] scalar,
    input  logic          sel_hi,
    output logic [VW-1:0] ins_out,
    output logic [VW-1:0] ext_out
);
    vec_halves_t ins_v;
    always_comb begin
        ins_v = vec_a;
        if (sel_hi) ins_v.hi = scalar;
        else        ins_v.lo = scalar;
        ins_out = ins_v;
        ext_out = {{HW{1'b0}}, (sel_hi ? vec_a.hi : vec_a.lo)};
    end
endmodule

// File: rtl/vshuf_perm.sv
module vshuf_perm
    import vshuf_pkg::*;
(
    input  logic [VW-1:0] vec_a,
    input  logic [VW-1:0] vec_b,
    output logic [VW-1:0] pin32,
    output logic [VW-1:0] pin64,
    output logic [VW-1:0] px32,
    output logic [VW-1:0] px64
);
    localparam int IW32 = $clog2(N32);
    localparam int IW64 = $clog2(N64);
    localparam int LW32 = $clog2(PER_LANE32);
    localparam int LW64 = $clog2(PER_LANE64);

    logic [31:0] a32 [N32];
    logic [63:0] a64 [N64];

    genvar g;
    generate
        for (g = 0; g < N32; g++) begin : g_w32
            logic [IW32-1:0] xi;
            logic [IW32-1:0] li;
            assign a32[g] = vec_a[32*g +: 32];
            assign xi = vec_b[32*g +: IW32];
            assign li = IW32'((g / PER_LANE32) * PER_LANE32) + IW32'(vec_b[32*g +: LW32]);
            assign px32[32*g +: 32]  = a32[xi];
            assign pin32[32*g +: 32] = a32[li];
        end
        for (g = 0; g < N64; g++) begin : g_w64
            logic [IW64-1:0] xi;
            logic [IW64-1:0] li;
            assign a64[g] = vec_a[64*g +: 64];
            assign xi = vec_b[64*g +: IW64];
            assign li = IW64'((g / PER_LANE64) * PER_LANE64) + IW64'(vec_b[64*g +: LW64]);
            assign px64[64*g +: 64]  = a64[xi];
            assign pin64[64*g +: 64] = a64[li];
        end
    endgenerate
endmodule

// File: rtl/vshuf_qsel.sv
module vshuf_qsel
    import vshuf_pkg::*;
(
    input  vec_halves_t   vec_a,
    input  vec_halves_t   vec_b,
    input  logic [7:0]    imm,
    output logic [VW-1:0] q_out
);
    logic unused_imm_bits;
    assign unused_imm_bits = imm[2] ^ imm[6];

    vec_halves_t r;
    always_comb begin
        r.lo = imm[3] ? '0 : pick_quarter(vec_a, vec_b, imm[1:0]);
        r.hi = imm[7] ? '0 : pick_quarter(vec_a, vec_b, imm[5:4]);
        q_out = r;
    end
endmodule

// File: rtl/vshuf_unit.sv
module vshuf_unit
    import vshuf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [3:0]    op,
    input  logic [7:0]    imm,
    input  logic [255:0]  vec_a,
    input  logic [255:0]  vec_b,
    input  logic [127:0]  scalar,
    output logic          res_valid,
    output logic [255:0]  res_data
);
    logic [VW-1:0] bc_v, ins_v, ext_v, pin32_v, pin64_v, px32_v, px64_v, q_v;
    logic [VW-1:0] next_v;

    vshuf_bcast u_bcast (.op(op), .scalar(scalar), .bc_out(bc_v));

    vshuf_half u_half (
        .vec_a(vec_a), .scalar(scalar), .sel_hi(imm[0]),
        .ins_out(ins_v), .ext_out(ext_v)
    );

    vshuf_perm u_perm (
        .vec_a(vec_a), .vec_b(vec_b),
        .pin32(pin32_v), .pin64(pin64_v), .px32(px32_v), .px64(px64_v)
    );

    vshuf_qsel u_qsel (.vec_a(vec_a), .vec_b(vec_b), .imm(imm), .q_out(q_v));

    always_comb begin
        case (op)
            OP_BC8, OP_BC16, OP_BC32, OP_BC64, OP_BC128: next_v = bc_v;
            OP_INSERT:  next_v = ins_v;
            OP_EXTRACT: next_v = ext_v;
            OP_PIN32:   next_v = pin32_v;
            OP_PIN64:   next_v = pin64_v;
            OP_PX32:    next_v = px32_v;
            OP_PX64:    next_v = px64_v;
            OP_QSEL:    next_v = q_v;
            default:    next_v = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) res_data <= next_v;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!res_valid && res_data == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!res_valid && $stable(res_data)));

    // R3
    bcast8_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op == OP_BC8) |=> (res_data[255:248] == $past(scalar[7:0])
                                         && res_data[7:0] == $past(scalar[7:0])));

    // R4
    insert_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op == OP_INSERT) |=>
            ($past(imm[0]) ? res_data[127:0] == $past(vec_a[127:0])
                           : res_data[255:128] == $past(vec_a[255:128])));

    // R5
    extract_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op == OP_EXTRACT) |=> res_data[255:128] == '0);

    // R10
    qsel_zero_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op == OP_QSEL && imm[3]) |=> res_data[127:0] == '0);

    // R11
    undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op >= 4'd12) |=> res_data == '0);
endmodule

// File: tb/vshuf_unit_tb.sv
module vshuf_unit_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [3:0]   op;
    logic [7:0]   imm;
    logic [255:0] vec_a, vec_b;
    logic [127:0] scalar;
    logic         res_valid;
    logic [255:0] res_data;

    int n_vec = 0;
    int n_bad = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;
    logic [255:0] last_exp = '0;

    always #5 clk = ~clk;

    vshuf_unit u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .op(op), .imm(imm),
        .vec_a(vec_a), .vec_b(vec_b), .scalar(scalar),
        .res_valid(res_valid), .res_data(res_data)
    );

    function automatic logic [63:0] step(input logic [63:0] x);
        logic [63:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    task automatic rnd256(output logic [255:0] v);
        for (int k = 0; k < 4; k++) begin
            seed = step(seed);
            v[64*k +: 64] = seed;
        end
    endtask

    function automatic logic [255:0] model(input logic [3:0] o, input logic [7:0] im,
                                           input logic [255:0] a, input logic [255:0] b,
                                           input logic [127:0] s);
        logic [255:0] r = '0;
        logic [127:0] q [4];
        int idx;
        q[0] = a[127:0]; q[1] = a[255:128]; q[2] = b[127:0]; q[3] = b[255:128];
        case (o)
            4'd0: for (int i = 0; i < 32; i++) r[8*i +: 8] = s[7:0];
            4'd1: for (int i = 0; i < 16; i++) r[16*i +: 16] = s[15:0];
            4'd2: for (int i = 0; i < 8; i++) r[32*i +: 32] = s[31:0];
            4'd3: for (int i = 0; i < 4; i++) r[64*i +: 64] = s[63:0];
            4'd4: r = {s, s};
            4'd5: r = im[0] ? {s, a[127:0]} : {a[255:128], s};
            4'd6: r = {128'd0, (im[0] ? a[255:128] : a[127:0])};
            4'd7: for (int i = 0; i < 8; i++) begin
                idx = (i / 4) * 4 + int'(b[32*i +: 2]);
                r[32*i +: 32] = a[32*idx +: 32];
            end
            4'd8: for (int i = 0; i < 4; i++) begin
                idx = (i / 2) * 2 + int'(b[64*i]);
                r[64*i +: 64] = a[64*idx +: 64];
            end
            4'd9: for (int i = 0; i < 8; i++) begin
                idx = int'(b[32*i +: 3]);
                r[32*i +: 32] = a[32*idx +: 32];
            end
            4'd10: for (int i = 0; i < 4; i++) begin
                idx = int'(b[64*i +: 2]);
                r[64*i +: 64] = a[64*idx +: 64];
            end
            4'd11: begin
                r[127:0]   = im[3] ? 128'd0 : q[im[1:0]];
                r[255:128] = im[7] ? 128'd0 : q[im[5:4]];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [3:0] o, input logic [7:0] im,
                         input logic [255:0] a, input logic [255:0] b, input logic [127:0] s);
        req_valid = 1'b1; op = o; imm = im; vec_a = a; vec_b = b; scalar = s;
        last_exp = model(o, im, a, b, s);
        @(negedge clk);
        check({tag, " valid"}, {255'd0, res_valid}, 256'd1);
        check(tag, res_data, last_exp);
    endtask

    task automatic rnd_apply(input string tag, input logic [3:0] o, input logic [7:0] im);
        logic [255:0] a, b;
        logic [255:0] s;
        rnd256(a); rnd256(b); rnd256(s);
        apply(tag, o, im, a, b, s[127:0]);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [255:0] a, b, s;
        rst = 1'b1; req_valid = 1'b0; op = '0; imm = '0;
        vec_a = '0; vec_b = '0; scalar = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {255'd0, res_valid}, 256'd0);
        check("R1 data", res_data, 256'd0);
        rst = 1'b0;

        // R3 broadcasts of each width
        for (int o = 0; o < 5; o++)
            for (int k = 0; k < 20; k++) rnd_apply("R3", 4'(o), 8'(k));

        // R4 / R5 insert and extract, both halves
        for (int k = 0; k < 20; k++) begin
            rnd_apply("R4", 4'd5, 8'(k));
            rnd_apply("R5", 4'd6, 8'(k));
        end

        // R6..R9 permutes
        for (int k = 0; k < 100; k++) begin
            rnd_apply("R6", 4'd7, 8'h00);
            rnd_apply("R7", 4'd8, 8'h00);
            rnd_apply("R8", 4'd9, 8'h00);
            rnd_apply("R9", 4'd10, 8'h00);
        end

        // R6 lane isolation: lane0 zero, lane1 ones, all-max indices
        apply("R6 lane", 4'd7, 8'h00, {128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'd0},
              {8{32'h0000_0003}}, 128'd0);
        check("R6 lane lo", {128'd0, res_data[127:0]}, 256'd0);
        apply("R7 lane", 4'd8, 8'h00, {128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'd0},
              {4{64'h1}}, 128'd0);
        check("R7 lane lo", {128'd0, res_data[127:0]}, 256'd0);

        // R10 all immediates
        for (int k = 0; k < 256; k++) rnd_apply("R10", 4'd11, 8'(k));

        // R11 undefined codes
        for (int o = 12; o < 16; o++)
            for (int k = 0; k < 5; k++) rnd_apply("R11", 4'(o), 8'(k * 37));

        // R2 idle cycles hold result
        for (int k = 0; k < 10; k++) begin
            rnd_apply("R2 pre", 4'd9, 8'h00);
            rnd256(a); rnd256(b); rnd256(s);
            req_valid = 1'b0; op = 4'd11; imm = 8'(k); vec_a = a; vec_b = b; scalar = s[127:0];
            @(negedge clk);
            check("R2 idle valid", {255'd0, res_valid}, 256'd0);
            check("R2 idle hold", res_data, last_exp);
        end

        // R1 reset in mid-run
        rst = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        check("R1 mid valid", {255'd0, res_valid}, 256'd0);
        check("R1 mid data", res_data, 256'd0);
        rst = 1'b0; req_valid = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule